// File: doc/BRIEF.md
# Drift-Corrected Nanosecond Time Counter

This block keeps a free-running nanosecond time value that advances by a fixed nominal step every clock cycle. A drift corrector trims the counter's effective rate. Once per programmed interval it folds a small signed correction of 0 to 7 ns into that cycle's increment. Software sets the correction interval, the magnitude and the sign so that the counter tracks a reference clock to within parts per billion.

Software uses a two-word register interface. A control word holds the drift-counter reset. A configuration word holds the interval, the magnitude and the direction. The configuration word can only be changed while the drift counter is held in reset. The required order is: assert the reset, read it back, write the configuration, then release the reset. The interval count starts again from zero each time the reset is released. Converting a ppb request into a configuration word is done outside this block.

Top module: `drift_time_counter`

## Requirements
- R1: After rst_ni is asserted, time_o is 0, the control word reads 0, and the configuration word reads 0x0FFFFFFF (interval field all ones, magnitude 0, direction 0).
- R2: In any cycle with no correction due, time_o advances by exactly NOM_STEP_NS (8 by default).
- R3: Address 0 is the control word, and its bit 0 is the drift-counter reset. Address 1 is the configuration word: bits [27:0] hold the interval field p, bits [30:28] the magnitude, and bit 31 the direction. Both words read back through rd_data_o, which is combinational on rd_addr_i.
- R4: A write to the configuration word is ignored unless the drift-counter reset reads 1 at the time of the write.
- R5: After the drift-counter reset is released, a correction falls due at the end of every interval of (16·p + 8) ns. At 8 ns per cycle this is every 2p+1 cycles, and the first correction comes in the (2p+1)-th cycle after release.
- R6: In a cycle where a correction is due, time_o advances by 8 + magnitude when the direction is 1, and by 8 − magnitude when the direction is 0, as a single increment.
- R7: When the interval field is 0xFFFFFFF, no correction is ever applied.
- R8: While the drift-counter reset is 1, no correction is applied and the interval timer is held at zero. A partly elapsed interval is discarded, and counting restarts from zero on release.
- R9: A magnitude of 0 gives corrections that leave the increment at 8 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 is control, 1 is configuration |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 1 | Read address |
| rd_data_o | output | 32 | Read data (combinational) |
| time_o | output | 64 | Current time in nanoseconds |

## Verification
The bench builds the block with its default parameters: a 64-bit time value, an 8 ns nominal step and a 28-bit interval field. Because of the 8 ns step, small interval fields (p = 0, 1, 2) give corrections every 1, 3 or 5 cycles. This puts the exact cycle of each correction, a restart after a partly elapsed interval, and both signs within a few dozen cycles. The all-ones field and the zero magnitude are exercised directly at those same settings.

// File: rtl/drift_pkg.sv
package drift_pkg;
  parameter int PERIOD_W = 28;
  parameter int MAG_W    = 3;
  parameter int REG_W    = 32;

  typedef struct packed {
    logic                dir;
    logic [MAG_W-1:0]    mag;
    logic [PERIOD_W-1:0] period;
  } drift_cfg_t;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_CFG  = 1'b1;
endpackage

// File: rtl/drift_regs.sv
module drift_regs
  import drift_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rd_addr_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             drift_rst_o,
  output drift_cfg_t       cfg_o
);
  localparam drift_cfg_t CFG_RST = '{dir: 1'b0, mag: '0, period: '1};

  logic wr_ctrl, wr_cfg;
  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_cfg  = wr_en_i && (wr_addr_i == ADDR_CFG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drift_rst_o <= 1'b0;
      cfg_o       <= CFG_RST;
    end else begin
      if (wr_ctrl) drift_rst_o <= wr_data_i[0];
      // configuration is locked unless drift counter held in reset
      if (wr_cfg && drift_rst_o) cfg_o <= drift_cfg_t'(wr_data_i);
    end
  end

  always_comb begin
    if (rd_addr_i == ADDR_CFG) rd_data_o = REG_W'(cfg_o);
    else                       rd_data_o = {{(REG_W-1){1'b0}}, drift_rst_o};
  end

  assert_cfg_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cfg && !drift_rst_o) |=> $stable(cfg_o));
endmodule

// File: rtl/drift_interval.sv
module drift_interval #(
  parameter int PERIOD_W = 28,
  parameter int NOM_NS   = 8,
  parameter int TIMER_W  = PERIOD_W + 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                drift_rst_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                due_o
);
  logic [TIMER_W-1:0] timer_q, timer_d, sum, interval_ns;
  logic               disabled;

  assign interval_ns = {period_i, 4'b0000} + TIMER_W'(8);
  assign disabled    = &period_i;
  assign sum         = timer_q + TIMER_W'(NOM_NS);
  assign due_o       = !drift_rst_i && !disabled && (sum >= interval_ns);

  always_comb begin
    if (drift_rst_i || disabled) timer_d = '0;
    else if (due_o)              timer_d = sum - interval_ns;
    else                         timer_d = sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) timer_q <= '0;
    else         timer_q <= timer_d;
  end

  assert_timer_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drift_rst_i |=> (timer_q == '0));
endmodule

// File: rtl/time_accum.sv
module time_accum #(
  parameter int TIME_W = 64,
  parameter int NOM_NS = 8,
  parameter int MAG_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              due_i,
  input  logic              dir_i,
  input  logic [MAG_W-1:0]  mag_i,
  output logic [TIME_W-1:0] time_o
);
  logic [TIME_W-1:0] inc;

  // nominal step and correction merged into one increment
  always_comb begin
    if (!due_i)     inc = TIME_W'(NOM_NS);
    else if (dir_i) inc = TIME_W'(NOM_NS) + TIME_W'(mag_i);
    else            inc = TIME_W'(NOM_NS) - TIME_W'(mag_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) time_o <= '0;
    else         time_o <= time_o + inc;
  end
endmodule

// File: rtl/drift_time_counter.sv
module drift_time_counter
  import drift_pkg::*;
#(
  parameter int TIME_W      = 64,
  parameter int NOM_STEP_NS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic [TIME_W-1:0] time_o
);
  localparam int TIMER_W = PERIOD_W + 6;
  localparam int MAX_MAG = (1 << MAG_W) - 1;

  logic       drift_rst, due;
  drift_cfg_t cfg;

  drift_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .drift_rst_o(drift_rst), .cfg_o(cfg)
  );

  drift_interval #(.PERIOD_W(PERIOD_W), .NOM_NS(NOM_STEP_NS), .TIMER_W(TIMER_W)) u_interval (
    .clk_i, .rst_ni, .drift_rst_i(drift_rst), .period_i(cfg.period), .due_o(due)
  );

  time_accum #(.TIME_W(TIME_W), .NOM_NS(NOM_STEP_NS), .MAG_W(MAG_W)) u_time (
    .clk_i, .rst_ni, .due_i(due), .dir_i(cfg.dir), .mag_i(cfg.mag), .time_o
  );

  assert_nominal_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !due |=> (time_o == $past(time_o) + TIME_W'(NOM_STEP_NS)));

  assert_step_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    due |=> ((time_o - $past(time_o)) >= TIME_W'(NOM_STEP_NS - MAX_MAG)) &&
            ((time_o - $past(time_o)) <= TIME_W'(NOM_STEP_NS + MAX_MAG)));

  assert_no_corr_in_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drift_rst |-> !due);

  assert_disabled_period_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cfg.period) |-> !due);
endmodule

// File: tb/sim_drift_time_counter.sv
module sim_drift_time_counter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [31:0] rd_data;
  logic [63:0] time_v;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drift_time_counter u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .time_o(time_v)
  );

  function automatic logic [31:0] mk_cfg(bit dir, int mag, int period);
    return {dir, 3'(mag), 28'(period)};
  endfunction

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(bit addr, logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(bit addr, output logic [31:0] data);
    rd_addr = addr;
    #1;
    data = rd_data;
  endtask

  task automatic check_delta(string req, int cycles, longint unsigned exp);
    logic [63:0] t0;
    t0 = time_v;
    repeat (cycles) @(negedge clk);
    check(req, time_v - t0, exp);
  endtask

  // full programming sequence; returns at the negedge after release
  task automatic program_cfg(logic [31:0] cfg);
    logic [31:0] r;
    reg_write(1'b0, 32'h1);
    reg_read(1'b0, r);
    check("R3 ctrl readback", r, 32'h1);
    reg_write(1'b1, cfg);
    reg_read(1'b1, r);
    check("R3 cfg readback", r, cfg);
    reg_write(1'b0, 32'h0);
  endtask

  task automatic t_reset_state;
    logic [31:0] r;
    check("R1 time", time_v, 0);
    reg_read(1'b0, r); check("R1 ctrl", r, 0);
    reg_read(1'b1, r); check("R1 cfg", r, 32'h0FFF_FFFF);
  endtask

  task automatic t_nominal;
    check_delta("R2 nominal 10 cycles", 10, 80);
  endtask

  task automatic t_locked;
    logic [31:0] r;
    reg_write(1'b1, mk_cfg(1, 5, 3));
    reg_read(1'b1, r);
    check("R4 cfg ignored when unlocked", r, 32'h0FFF_FFFF);
    check_delta("R4 no effect on time", 7, 56);
  endtask

  task automatic t_add_every_cycle;
    program_cfg(mk_cfg(1, 3, 0));
    check_delta("R6 add p=0 first", 1, 11);
    check_delta("R5 add p=0 run", 4, 44);
  endtask

  task automatic t_sub_p1;
    program_cfg(mk_cfg(0, 5, 1));
    check_delta("R5 p=1 cycle1", 1, 8);
    check_delta("R5 p=1 cycle2", 1, 8);
    check_delta("R6 p=1 subtract on cycle3", 1, 3);
    check_delta("R5 p=1 two intervals", 6, 38);
  endtask

  task automatic t_hold_and_restart;
    logic [31:0] r;
    program_cfg(mk_cfg(1, 4, 2));
    check_delta("R8 partial interval", 3, 24);
    reg_write(1'b0, 32'h1);
    reg_read(1'b0, r);
    check("R8 ctrl set", r, 1);
    check_delta("R8 held no correction", 8, 64);
    reg_write(1'b0, 32'h0);
    check_delta("R8 restart four cycles", 4, 32);
    check_delta("R8 restart fifth cycle", 1, 12);
  endtask

  task automatic t_disabled;
    program_cfg(mk_cfg(1, 7, 32'h0FFF_FFFF));
    check_delta("R7 all-ones period", 20, 160);
  endtask

  task automatic t_zero_mag;
    program_cfg(mk_cfg(1, 0, 0));
    check_delta("R9 zero magnitude", 6, 48);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_nominal();
    t_locked();
    t_add_every_cycle();
    t_sub_p1();
    t_hold_and_restart();
    t_disabled();
    t_zero_mag();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule